// File: doc/BRIEF.md
# ECC-protected SRAM with error capture

This block is a 64-bit-wide on-chip SRAM protected by a single-error-correct, double-error-detect code. Every write stores the 64 data bits together with 8 check bits. Every read decodes the stored 72-bit codeword. A single flipped bit is repaired before the data reaches the requester. Two flipped bits are reported as uncorrectable.

The block keeps a record of the most recent error event whose type is enabled for reporting. The record holds the raw data bits as they came out of the array before correction, the address that was read, and a 2-bit error type. An enabled uncorrectable error also raises a level interrupt request. The request stays high until a write-one-to-clear pulse removes it.

After power-up the array holds random bits. Software must write every location with a full 64-bit word before reading it. For test purposes, an error-injection mask is XORed into the codeword as it is written.

Top module: `ecc_sram_capture`

## Requirements
- R1: Data bit i of the word is stored at codeword position p, where p is the (i+1)-th integer in 3..71 that is not a power of two. Positions 1, 2, 4, 8, 16, 32 and 64 hold the Hamming check bits, and position 0 holds the even parity of the whole codeword. A read whose address is sampled at clock edge k returns the last written word on `rdata_o`, with `rvalid_o` high for exactly one cycle, after edge k+1.
- R2: After any single flipped codeword bit (positions 0..71), the read returns the originally written data, with `corr_o`=1 and `uncorr_o`=0.
- R3: After two flipped codeword bits, the read shows `uncorr_o`=1 and `corr_o`=0.
- R4: A single-bit error while `rpt_single_en_i`=1 sets `cap_type_o`=2'b01 and `cap_addr_o`=read address. It also sets `cap_data_o` to the uncorrected data bits (written data XOR the flipped data positions). All three update after edge k+1.
- R5: An uncorrectable error while `rpt_multi_en_i`=1 sets `cap_type_o`=2'b10, `cap_addr_o` and `cap_data_o` in the same way as R4.
- R6: An error whose report enable is 0, or a read with no error, leaves `cap_data_o`, `cap_addr_o` and `cap_type_o` unchanged.
- R7: `irq_o` rises after edge k+1 of an uncorrectable read while `rpt_multi_en_i`=1. It stays high until an edge where `irq_clr_i`=1. If the set and the clear fall on the same edge, the set wins.
- R8: Single-bit errors never set `irq_o`, and uncorrectable errors with `rpt_multi_en_i`=0 do not set it.
- R9: After reset, `rvalid_o`, `corr_o`, `uncorr_o`, `irq_o`, `cap_addr_o` and `cap_type_o` are 0. `cap_data_o` is undefined until the first capture.
- R10: An all-zero injection mask stores a clean codeword. A one in mask bit p inverts codeword position p as it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 64 | Write data |
| inj_mask_i | input | 72 | Error-injection mask, XORed into the codeword on write |
| rpt_single_en_i | input | 1 | Enable capture of corrected errors |
| rpt_multi_en_i | input | 1 | Enable capture and interrupt for uncorrectable errors |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| rdata_o | output | 64 | Corrected read data |
| rvalid_o | output | 1 | Read data valid |
| corr_o | output | 1 | Current read had a corrected error |
| uncorr_o | output | 1 | Current read had an uncorrectable error |
| irq_o | output | 1 | Interrupt request level |
| cap_data_o | output | 64 | Raw data of the last reported error |
| cap_addr_o | output | ADDR_W | Address of the last reported error |
| cap_type_o | output | 2 | Type of the last reported error (01 single, 10 multi) |

## Verification
The bench builds the block with DEPTH=16, so ADDR_W is 4. This puts both the first and the last word of the array within a few transactions. The small array leaves room for a sweep of single flips over all 72 codeword positions, including each check bit and the overall parity bit. Double flips are drawn from data-only, check-only and mixed position pairs. The syndrome path is therefore exercised from both kinds of bit.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DW = 64;
  localparam int PW = 7;
  localparam int CW = 72;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'b00,
    ERR_SINGLE = 2'b01,
    ERR_MULTI  = 2'b10
  } err_kind_e;

  // codeword position of data bit idx: idx-th non-power-of-two in 3..CW-1
  function automatic int data_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 3; p < CW; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == idx) res = p;
        cnt++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_sram_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] cw_o
);
  logic [CW-1:0] ham;
  logic          par;

  always_comb begin
    ham = '0;
    par = 1'b0;
    for (int i = 0; i < DW; i++) ham[data_pos(i)] = data_i[i];
    for (int p = 0; p < PW; p++) begin
      par = 1'b0;
      for (int j = 1; j < CW; j++) begin
        if (((j >> p) & 1) == 1) par = par ^ ham[j];
      end
      ham[1 << p] = par;
    end
    ham[0] = ^ham[CW-1:1];
  end

  assign cw_o = ham;
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_sram_pkg::*;
(
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] raw_o,
  output err_kind_e     kind_o
);
  logic [PW-1:0] syn;
  logic          odd;
  logic [CW-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int j = 1; j < CW; j++) begin
      if (cw_i[j]) syn = syn ^ PW'(j);
    end
    odd    = ^cw_i;
    fixed  = cw_i;
    kind_o = ERR_NONE;
    if (odd) begin
      if (int'(syn) < CW) begin
        kind_o = ERR_SINGLE;
        fixed[int'(syn)] = ~cw_i[int'(syn)];
      end else begin
        kind_o = ERR_MULTI;
      end
    end else if (syn != '0) begin
      kind_o = ERR_MULTI;
    end
    for (int i = 0; i < DW; i++) begin
      data_o[i] = fixed[data_pos(i)];
      raw_o[i]  = cw_i[data_pos(i)];
    end
  end
endmodule

// File: rtl/ecc_sram_array.sv
module ecc_sram_array
  import ecc_sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CW-1:0]     wcw_i,
  output logic [CW-1:0]     rcw_o
);
  logic [CW-1:0] mem_q [DEPTH];
  logic [CW-1:0] rcw_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wcw_i;
    if (re_i) rcw_q <= mem_q[addr_i];
  end

  assign rcw_o = rcw_q;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  err_kind_e         kind_i,
  input  logic [DW-1:0]     raw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              single_en_i,
  input  logic              multi_en_i,
  input  logic              clr_i,
  output logic [DW-1:0]     cap_data_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [1:0]        cap_type_o,
  output logic              irq_o
);
  logic              hit_single, hit_multi, cap_en;
  logic [DW-1:0]     cap_data_q;
  logic [ADDR_W-1:0] cap_addr_q;
  logic [1:0]        cap_type_q;
  logic              irq_q;

  assign hit_single = valid_i && (kind_i == ERR_SINGLE) && single_en_i;
  assign hit_multi  = valid_i && (kind_i == ERR_MULTI) && multi_en_i;
  assign cap_en     = hit_single || hit_multi;

  // data register is left without reset: undefined until first capture
  always_ff @(posedge clk_i) begin
    if (cap_en) cap_data_q <= raw_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr_q <= '0;
      cap_type_q <= 2'b00;
      irq_q      <= 1'b0;
    end else begin
      if (cap_en) begin
        cap_addr_q <= addr_i;
        cap_type_q <= kind_i;
      end
      if (hit_multi)  irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end

  assign cap_data_o = cap_data_q;
  assign cap_addr_o = cap_addr_q;
  assign cap_type_o = cap_type_q;
  assign irq_o      = irq_q;

  AST_IRQ_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o); // R7
  AST_IRQ_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && kind_i == ERR_MULTI && multi_en_i |=> irq_o); // R7
  AST_IRQ_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !(valid_i && kind_i == ERR_MULTI && multi_en_i) |=> !irq_o); // R8
  AST_CAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ((kind_i == ERR_SINGLE && single_en_i) || (kind_i == ERR_MULTI && multi_en_i)))
    |=> $stable(cap_addr_o) && $stable(cap_type_o)); // R6
  AST_CAP_TYPE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_type_o != 2'b11); // R4
endmodule

// File: rtl/ecc_sram_capture.sv
module ecc_sram_capture
  import ecc_sram_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  input  logic [71:0]       inj_mask_i,
  input  logic              rpt_single_en_i,
  input  logic              rpt_multi_en_i,
  input  logic              irq_clr_i,
  output logic [63:0]       rdata_o,
  output logic              rvalid_o,
  output logic              corr_o,
  output logic              uncorr_o,
  output logic              irq_o,
  output logic [63:0]       cap_data_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [1:0]        cap_type_o
);
  logic [CW-1:0]     enc_cw, rd_cw;
  logic [DW-1:0]     dec_data, dec_raw;
  err_kind_e         dec_kind;
  logic              rd_pend_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DW-1:0]     rdata_q;
  logic              rvalid_q, corr_q, uncorr_q;

  ecc_encoder u_enc (
    .data_i (wdata_i),
    .cw_o   (enc_cw)
  );

  ecc_sram_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (wr_en_i),
    .re_i   (rd_en_i),
    .addr_i (addr_i),
    .wcw_i  (enc_cw ^ inj_mask_i),
    .rcw_o  (rd_cw)
  );

  ecc_decoder u_dec (
    .cw_i   (rd_cw),
    .data_o (dec_data),
    .raw_o  (dec_raw),
    .kind_o (dec_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      rvalid_q  <= 1'b0;
      corr_q    <= 1'b0;
      uncorr_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rd_pend_q <= rd_en_i;
      if (rd_en_i) rd_addr_q <= addr_i;
      rvalid_q  <= rd_pend_q;
      corr_q    <= rd_pend_q && (dec_kind == ERR_SINGLE);
      uncorr_q  <= rd_pend_q && (dec_kind == ERR_MULTI);
      if (rd_pend_q) rdata_q <= dec_data;
    end
  end

  ecc_err_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rd_pend_q),
    .kind_i      (dec_kind),
    .raw_i       (dec_raw),
    .addr_i      (rd_addr_q),
    .single_en_i (rpt_single_en_i),
    .multi_en_i  (rpt_multi_en_i),
    .clr_i       (irq_clr_i),
    .cap_data_o  (cap_data_o),
    .cap_addr_o  (cap_addr_o),
    .cap_type_o  (cap_type_o),
    .irq_o       (irq_o)
  );

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign corr_o   = corr_q;
  assign uncorr_o = uncorr_q;

  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corr_o && uncorr_o)); // R3
  AST_FLAG_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corr_o || uncorr_o) |-> rvalid_o); // R2
  AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> ##1 rvalid_o); // R1
  AST_KIND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> $onehot0(dec_kind)); // R2
endmodule

// File: tb/ecc_sram_capture_bench.sv
module ecc_sram_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int AW         = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [63:0]   wdata = '0;
  logic [71:0]   mask = '0;
  logic          sen = 1'b0, men = 1'b0, clr = 1'b0;
  logic [63:0]   rdata, cap_data;
  logic          rvalid, corr, uncorr, irq;
  logic [AW-1:0] cap_addr;
  logic [1:0]    cap_type;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_sram_capture #(.DEPTH(DEPTH)) u_ecc_sram_capture (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .inj_mask_i(mask),
    .rpt_single_en_i(sen), .rpt_multi_en_i(men), .irq_clr_i(clr),
    .rdata_o(rdata), .rvalid_o(rvalid), .corr_o(corr), .uncorr_o(uncorr),
    .irq_o(irq), .cap_data_o(cap_data), .cap_addr_o(cap_addr), .cap_type_o(cap_type)
  );

  // codeword position of data bit i, from R1
  function automatic int bit_pos(input int i);
    int k;
    k = -1;
    for (int p = 3; p < 72; p++) begin
      if (!(p == 4 || p == 8 || p == 16 || p == 32 || p == 64)) begin
        k++;
        if (k == i) return p;
      end
    end
    return 0;
  endfunction

  function automatic logic [63:0] raw_of(input logic [63:0] d, input logic [71:0] m);
    logic [63:0] r;
    r = d;
    for (int i = 0; i < 64; i++) if (m[bit_pos(i)]) r[i] = ~r[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [63:0] d, input logic [71:0] m);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; mask = m;
    @(negedge clk);
    wr_en = 1'b0; mask = '0;
  endtask

  // returns at the negedge after edge k+1
  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 rvalid", 72'(rvalid), 72'd0);
    chk("R9 corr", 72'(corr), 72'd0);
    chk("R9 uncorr", 72'(uncorr), 72'd0);
    chk("R9 irq", 72'(irq), 72'd0);
    chk("R9 cap_addr", 72'(cap_addr), 72'd0);
    chk("R9 cap_type", 72'(cap_type), 72'd0);
  endtask

  task automatic t_clean();
    logic [63:0] pats [4];
    pats[0] = 64'h0; pats[1] = '1; pats[2] = 64'hA5A5_5A5A_0123_4567; pats[3] = 64'h8000_0000_0000_0001;
    sen = 1'b1; men = 1'b1;
    for (int i = 0; i < 4; i++) begin
      do_write(AW'(i * 5), pats[i], '0);
      do_read(AW'(i * 5));
      chk("R1 data", 72'(rdata), 72'(pats[i]));
      chk("R10 clean flags", 72'({rvalid, corr, uncorr}), 72'b100);
      chk("R6 no capture on clean", 72'(cap_type), 72'd0);
    end
    @(negedge clk);
    chk("R1 rvalid one cycle", 72'(rvalid), 72'd0);
  endtask

  task automatic t_single_sweep();
    logic [63:0] d;
    logic [71:0] m;
    sen = 1'b1; men = 1'b0;
    for (int b = 0; b < 72; b++) begin
      d = {32'hC0DE_0000 + 32'(b), 32'h1357_9BDF ^ 32'(b * 7)};
      m = 72'd1 << b;
      do_write(AW'(DEPTH - 1 - (b % DEPTH)), d, m);
      do_read(AW'(DEPTH - 1 - (b % DEPTH)));
      chk("R2 corrected data", 72'(rdata), 72'(d));
      chk("R2 flags", 72'({corr, uncorr}), 72'b10);
      chk("R4 cap_type", 72'(cap_type), 72'b01);
      chk("R4 cap_addr", 72'(cap_addr), 72'(DEPTH - 1 - (b % DEPTH)));
      chk("R4 cap_data raw", 72'(cap_data), 72'(raw_of(d, m)));
      chk("R8 no irq on single", 72'(irq), 72'd0);
    end
  endtask

  task automatic t_double();
    int pa [5] = '{0, 1, 5, 64, 70};
    int pb [5] = '{1, 2, 70, 3, 71};
    logic [63:0] d;
    logic [71:0] m;
    sen = 1'b1; men = 1'b1;
    for (int i = 0; i < 5; i++) begin
      d = 64'hFEED_F00D_0000_0000 | 64'(i);
      m = (72'd1 << pa[i]) | (72'd1 << pb[i]);
      clr = 1'b1; @(negedge clk); clr = 1'b0;
      do_write(AW'(i), d, m);
      do_read(AW'(i));
      chk("R3 flags", 72'({corr, uncorr}), 72'b01);
      chk("R5 cap_type", 72'(cap_type), 72'b10);
      chk("R5 cap_addr", 72'(cap_addr), 72'(i));
      chk("R5 cap_data raw", 72'(cap_data), 72'(raw_of(d, m)));
      chk("R7 irq set", 72'(irq), 72'd1);
    end
  endtask

  task automatic t_disabled();
    logic [63:0] d0;
    d0 = 64'h1111_2222_3333_4444;
    sen = 1'b1; men = 1'b0;
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    do_write(4'd7, d0, 72'd1 << 10);
    do_read(4'd7);
    chk("R4 setup", 72'(cap_addr), 72'd7);
    sen = 1'b0;
    do_write(4'd9, 64'h5, 72'd1 << 20);
    do_read(4'd9);
    chk("R6 single disabled data ok", 72'(rdata), 72'h5);
    chk("R6 single disabled addr", 72'(cap_addr), 72'd7);
    chk("R6 single disabled type", 72'(cap_type), 72'b01);
    chk("R6 single disabled cap_data", 72'(cap_data), 72'(raw_of(d0, 72'd1 << 10)));
    sen = 1'b1;
    do_write(4'd11, 64'h6, 72'h3 << 30);
    do_read(4'd11);
    chk("R3 disabled multi flag", 72'(uncorr), 72'd1);
    chk("R6 multi disabled addr", 72'(cap_addr), 72'd7);
    chk("R6 multi disabled type", 72'(cap_type), 72'b01);
    chk("R8 multi disabled no irq", 72'(irq), 72'd0);
  endtask

  task automatic t_irq();
    sen = 1'b0; men = 1'b1;
    do_write(4'd3, 64'hABCD, 72'h5);
    do_read(4'd3);
    chk("R7 irq up", 72'(irq), 72'd1);
    repeat (3) @(negedge clk);
    chk("R7 irq held", 72'(irq), 72'd1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R7 irq cleared", 72'(irq), 72'd0);
    // set and clear on the same edge
    @(negedge clk);
    rd_en = 1'b1; addr = 4'd3; clr = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    chk("R7 set wins over clear", 72'(irq), 72'd1);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk("R7 clear after", 72'(irq), 72'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single_sweep();
    t_double();
    t_disabled();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule